// File: doc/BRIEF.md
# Serial Flash SPI Master with Sized Transmit Ports

This block is a register-mapped SPI master for a serial flash. Software sends 32-bit words over a simple register bus. Each word goes into a transmit FIFO together with a byte count from 1 to 4. The register address that was written sets that count, so software can send a one-byte opcode, a three-byte address or a full data word without repacking it. The engine sends the queued bytes on one MOSI line. Bytes leave the word starting from the least significant lane, and each byte goes out most significant bit first. MISO is sampled at the same time. When an entry finishes, the bytes received for it are packed into one word and pushed into a receive FIFO.

Software sets the clock divider, the clock polarity, the sampling phase and the chip-select policy, and chooses whether shifting starts on its own or waits for a start command. Status bits show the fill level of both FIFOs and two sticky error flags. An interrupt-enable mask selects which status bits drive the interrupt line.

Top module: `sflash_spi_master`

## Requirements
- R1: After reset the status register (0x04) reads 0x06, the mask register (0x10) reads 0, `spi_cs_n` is 1, `spi_sclk` is 0 and `irq` is 0.
- R2: A write to 0x80, 0x84, 0x88 or 0x1C queues a word that sends 1, 2, 3 or 4 bytes, taken from byte lane 0 upward, each byte MSB first.
- R3: The word received for an n-byte entry holds its first byte in lane 4-n, the following bytes in the lanes above it, and zeros in lanes below 4-n. Reading 0x20 pops one word.
- R4: Control bit 1 sets the idle level of `spi_sclk`. With control bit 2 at 0, MISO is sampled on the leading clock edge and MOSI changes on the trailing edge. With bit 2 at 1, MISO is sampled on the trailing edge.
- R5: Control bits [5:3] hold a code N, and one `spi_sclk` period lasts 2<<N clock cycles.
- R6: With control bit 14 at 0, `spi_cs_n` is low while the engine shifts and stays low between entries that follow each other without a gap. With bit 14 at 1, `spi_cs_n` equals control bit 10.
- R7: With control bit 15 at 1, queued words wait until a control write with bit 16 set. That command lets the queue drain.
- R8: Bit 0 of the enable register (0x14) gates all shifting. Clearing it aborts the current entry, returns `spi_sclk` to its idle level and releases the automatic chip select.
- R9: The status bits are: 1 TX FIFO empty, 2 TX FIFO not full, 3 TX FIFO full, 4 RX FIFO not empty, 5 RX FIFO full. Each FIFO holds 63 words.
- R10: A transmit write while the TX FIFO is full is dropped and sets sticky status bit 0. A read of 0x20 while the RX FIFO is empty returns 0 and sets sticky status bit 6. Writing a 1 to 0x04 clears the matching sticky bit.
- R11: Writing 1s to 0x08 sets mask bits and writing 1s to 0x0C clears them. Register 0x10 reads the mask, and `irq` is the OR over all bits of (status AND mask).
- R12: The engine starts no entry unless the RX FIFO has room for the entry's result, so no received word is ever lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; a read of 0x20 pops the RX FIFO |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the same cycle as `reg_rd` |
| irq | output | 1 | Interrupt request |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The hardest state to reach is the one where the receive FIFO is completely full while transmit words are still waiting. The engine must then hold back, and it must resume exactly when a single word is read out.

To get there, the bench first keeps shifting disabled and overfills the transmit queue, which also exercises the overflow flag. It then enables shifting so that 63 one-byte results fill the receive side. Next it queues one more word and confirms that no clock or chip select appears. Finally it drains the receive side, checking every word against a bit-accurate slave model that both drives MISO and checks each MOSI byte against a scoreboard queue.

// File: rtl/spim_pkg.sv
package spim_pkg;
    localparam logic [7:0] A_CTRL  = 8'h00;
    localparam logic [7:0] A_STAT  = 8'h04;
    localparam logic [7:0] A_IEN   = 8'h08;
    localparam logic [7:0] A_IDIS  = 8'h0C;
    localparam logic [7:0] A_IMASK = 8'h10;
    localparam logic [7:0] A_EN    = 8'h14;
    localparam logic [7:0] A_TX4   = 8'h1C;
    localparam logic [7:0] A_RX    = 8'h20;
    localparam logic [7:0] A_TX1   = 8'h80;
    localparam logic [7:0] A_TX2   = 8'h84;
    localparam logic [7:0] A_TX3   = 8'h88;

    // writable control bits: 15 manual start, 14 manual select, 10 select level, 5:0 mode/div
    localparam logic [15:0] CTRL_RW    = 16'hC43F;
    localparam logic [15:0] CTRL_RESET = 16'h0400;

    // byte count minus one travels with each queued word
    typedef struct packed {
        logic [1:0]  code;
        logic [31:0] data;
    } tx_entry_t;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 63,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             empty,
    output logic             full,
    output logic [CW-1:0]    count
);
    typedef struct packed {
        logic [AW-1:0] rd;
        logic [AW-1:0] wr;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t s_q, s_d;
    logic [WIDTH-1:0] mem [DEPTH];
    logic do_push, do_pop;

    assign empty   = (s_q.cnt == '0);
    assign full    = (s_q.cnt == CW'(DEPTH));
    assign count   = s_q.cnt;
    assign rdata   = mem[s_q.rd];
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        s_d = s_q;
        if (do_push) s_d.wr = wrap_inc(s_q.wr);
        if (do_pop)  s_d.rd = wrap_inc(s_q.rd);
        case ({do_push, do_pop})
            2'b10:   s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[s_q.wr] <= wdata;
    end

    assert_fifo_stays_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> full);
    assert_fifo_empty_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> empty);
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter #(
    parameter int DIVW = 3,
    localparam int DCW = (1 << DIVW) - 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_en,
    input  logic            cpol,
    input  logic            cpha,
    input  logic [DIVW-1:0] div,
    input  logic            can_start,
    input  logic [1:0]      entry_code,
    input  logic [31:0]     entry_data,
    output logic            entry_pop,
    output logic            rx_push,
    output logic [31:0]     rx_word,
    output logic            busy,
    output logic            sclk,
    output logic            mosi,
    input  logic            miso
);
    typedef struct packed {
        logic            busy;
        logic            phase;
        logic [DCW-1:0]  dcnt;
        logic [4:0]      bitc;
        logic [1:0]      code;
        logic [31:0]     word;
        logic [7:0]      rxb;
        logic [31:0]     rxw;
    } sh_st_t;

    sh_st_t s_q, s_d;
    logic [DCW-1:0] half_m1;
    logic tick, sample, done;
    logic [7:0] rxb_n;

    assign half_m1 = (DCW'(1) << div) - 1'b1;
    assign tick    = s_q.busy && (s_q.dcnt == half_m1);
    assign sample  = tick && (s_q.phase == cpha);
    assign rxb_n   = sample ? {s_q.rxb[6:0], miso} : s_q.rxb;

    always_comb begin
        s_d       = s_q;
        entry_pop = 1'b0;
        rx_push   = 1'b0;
        rx_word   = {rxb_n, s_q.rxw[31:8]};
        done      = 1'b0;
        if (s_q.busy && !run_en) begin
            s_d.busy  = 1'b0;
            s_d.phase = 1'b0;
        end else if (tick) begin
            s_d.dcnt  = '0;
            s_d.phase = !s_q.phase;
            s_d.rxb   = rxb_n;
            if (s_q.phase) begin
                if (s_q.bitc[2:0] == 3'd7) s_d.rxw = rx_word;
                if (s_q.bitc == {s_q.code, 3'b111}) begin
                    rx_push  = 1'b1;
                    done     = 1'b1;
                    s_d.busy = 1'b0;
                end else begin
                    s_d.bitc = s_q.bitc + 1'b1;
                end
            end
        end else if (s_q.busy) begin
            s_d.dcnt = s_q.dcnt + 1'b1;
        end
        if (run_en && can_start && (!s_q.busy || done)) begin
            entry_pop = 1'b1;
            s_d.busy  = 1'b1;
            s_d.phase = 1'b0;
            s_d.dcnt  = '0;
            s_d.bitc  = '0;
            s_d.code  = entry_code;
            s_d.word  = entry_data;
            s_d.rxw   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy = s_q.busy;
    assign sclk = cpol ^ s_q.phase;
    assign mosi = s_q.busy && s_q.word[{s_q.bitc[4:3], ~s_q.bitc[2:0]}];

    assert_sclk_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sclk == cpol));
    assert_mosi_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && run_en && !tick) |=> $stable(mosi));
    assert_push_while_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> busy);
endmodule

// File: rtl/sflash_spi_master.sv
module sflash_spi_master #(
    parameter int FIFO_DEPTH = 63,
    parameter int DIVW       = 3,
    localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq,
    output logic        spi_sclk,
    output logic        spi_cs_n,
    output logic        spi_mosi,
    input  logic        spi_miso
);
    import spim_pkg::*;

    typedef struct packed {
        logic [15:0] ctrl;
        logic        en;
        logic [6:0]  mask;
        logic        txov;
        logic        rxun;
        logic        go;
    } regs_t;

    regs_t r_q, r_d;
    tx_entry_t tx_in, tx_out;
    logic tx_push, tx_pop, tx_empty, tx_full;
    logic rx_push, rx_pop, rx_empty, rx_full;
    logic [31:0] rx_in, rx_out;
    logic [CW-1:0] tx_cnt, rx_cnt;
    logic busy, can_start, rx_room, tx_addr;
    logic [6:0] status;

    spim_fifo #(.WIDTH($bits(tx_entry_t)), .DEPTH(FIFO_DEPTH)) i_txq (
        .clk, .rst_n, .push(tx_push), .wdata(tx_in), .pop(tx_pop),
        .rdata(tx_out), .empty(tx_empty), .full(tx_full), .count(tx_cnt));

    spim_fifo #(.WIDTH(32), .DEPTH(FIFO_DEPTH)) i_rxq (
        .clk, .rst_n, .push(rx_push), .wdata(rx_in), .pop(rx_pop),
        .rdata(rx_out), .empty(rx_empty), .full(rx_full), .count(rx_cnt));

    spim_shifter #(.DIVW(DIVW)) i_shift (
        .clk, .rst_n, .run_en(r_q.en), .cpol(r_q.ctrl[1]), .cpha(r_q.ctrl[2]),
        .div(r_q.ctrl[3 +: DIVW]), .can_start, .entry_code(tx_out.code),
        .entry_data(tx_out.data), .entry_pop(tx_pop), .rx_push, .rx_word(rx_in),
        .busy, .sclk(spi_sclk), .mosi(spi_mosi), .miso(spi_miso));

    // room must account for a result landing in this very cycle
    assign rx_room   = rx_push ? (rx_cnt < CW'(FIFO_DEPTH - 1)) : !rx_full;
    assign can_start = !tx_empty && rx_room && (!r_q.ctrl[15] || r_q.go);
    assign status    = {r_q.rxun, rx_full, !rx_empty, tx_full, !tx_full, tx_empty, r_q.txov};
    assign irq       = |(status & r_q.mask);
    assign spi_cs_n  = r_q.ctrl[14] ? r_q.ctrl[10] : !busy;
    assign tx_addr   = (reg_addr == A_TX1) || (reg_addr == A_TX2) ||
                       (reg_addr == A_TX3) || (reg_addr == A_TX4);
    assign tx_push   = reg_wr && tx_addr && !tx_full;
    assign rx_pop    = reg_rd && (reg_addr == A_RX) && !rx_empty;

    always_comb begin
        tx_in.data = reg_wdata;
        case (reg_addr)
            A_TX1:   tx_in.code = 2'd0;
            A_TX2:   tx_in.code = 2'd1;
            A_TX3:   tx_in.code = 2'd2;
            default: tx_in.code = 2'd3;
        endcase
    end

    always_comb begin
        case (reg_addr)
            A_CTRL:  reg_rdata = {16'h0, r_q.ctrl};
            A_STAT:  reg_rdata = {25'h0, status};
            A_IMASK: reg_rdata = {25'h0, r_q.mask};
            A_EN:    reg_rdata = {31'h0, r_q.en};
            A_RX:    reg_rdata = rx_empty ? 32'h0 : rx_out;
            default: reg_rdata = 32'h0;
        endcase
    end

    always_comb begin
        r_d = r_q;
        if (!busy && tx_empty) r_d.go = 1'b0;
        if (reg_wr) begin
            case (reg_addr)
                A_CTRL: begin
                    r_d.ctrl = reg_wdata[15:0] & CTRL_RW;
                    if (reg_wdata[16]) r_d.go = 1'b1;
                end
                A_STAT: begin
                    if (reg_wdata[0]) r_d.txov = 1'b0;
                    if (reg_wdata[6]) r_d.rxun = 1'b0;
                end
                A_IEN:   r_d.mask = r_q.mask | reg_wdata[6:0];
                A_IDIS:  r_d.mask = r_q.mask & ~reg_wdata[6:0];
                A_EN:    r_d.en = reg_wdata[0];
                default: ;
            endcase
            if (tx_addr && tx_full) r_d.txov = 1'b1;
        end
        if (reg_rd && (reg_addr == A_RX) && rx_empty) r_d.rxun = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{ctrl: CTRL_RESET, en: 1'b0, mask: '0, txov: 1'b0, rxun: 1'b0, go: 1'b0};
        else        r_q <= r_d;
    end

    assert_cs_covers_clock_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_q.ctrl[14] && (spi_sclk != r_q.ctrl[1])) |-> !spi_cs_n);
    assert_manual_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ctrl[15] && !r_q.go && !busy) |=> !busy);
    assert_halt_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.en |=> !busy);
    assert_tx_overflow_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && tx_addr && tx_full) |=> r_q.txov);
    assert_rx_underflow_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && (reg_addr == A_RX) && rx_empty) |=> r_q.rxun);
    assert_no_rx_loss_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> !rx_full);
endmodule

// File: tb/test_sflash_spi_master.sv
`timescale 1ns/1ps
module test_sflash_spi_master;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic irq, spi_sclk, spi_cs_n, spi_mosi, spi_miso;

    always #10 clk = !clk;

    sflash_spi_master i_sflash_spi_master (
        .clk, .rst_n, .reg_wr, .reg_rd, .reg_addr, .reg_wdata, .reg_rdata,
        .irq, .spi_sclk, .spi_cs_n, .spi_mosi, .spi_miso);

    int n_checks = 0, n_fail = 0;
    logic [7:0]  exp_mosi [$];
    logic [31:0] exp_rx [$];
    int plan_idx = 0;
    int mbit = 0;
    int sbits = 0;
    logic [7:0] sh = '0;
    logic cfg_cpol = 1'b0, cfg_cpha = 1'b0;
    logic prev_sclk = 1'b0, prev_mosi = 1'b0, prev_cs = 1'b1;
    int cs_rises = 0;
    int since_rise = 0, last_period = 0;
    logic [31:0] v;

    function automatic logic [7:0] pat(input int k);
        return 8'h5A ^ 8'(k * 29);
    endfunction

    assign spi_miso = pat(mbit / 8)[7 - (mbit % 8)];

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // slave model and MOSI scoreboard monitor
    always @(negedge clk) begin
        if (spi_sclk != prev_sclk && !prev_cs) begin
            if ((prev_sclk == cfg_cpol) == (cfg_cpha == 1'b0)) begin
                sh = {sh[6:0], prev_mosi};
                sbits++;
                if (sbits == 8) begin
                    sbits = 0;
                    if (exp_mosi.size() == 0) check(0, "R2 unexpected byte", {24'h0, sh}, 32'h0);
                    else begin
                        logic [7:0] e;
                        e = exp_mosi.pop_front();
                        check(sh == e, "R2 mosi byte", {24'h0, sh}, {24'h0, e});
                    end
                end
            end
            if (prev_sclk != cfg_cpol) mbit++;
        end
        if (spi_sclk && !prev_sclk) begin
            last_period = since_rise;
            since_rise = 0;
        end
        since_rise++;
        if (spi_cs_n && !prev_cs) cs_rises++;
        prev_sclk = spi_sclk;
        prev_mosi = spi_mosi;
        prev_cs = spi_cs_n;
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    // driver: queue a word and record what the slave must see and return
    task automatic send(input int n, input logic [31:0] d, input bit accepted);
        logic [7:0] a;
        logic [31:0] w;
        a = (n == 1) ? 8'h80 : (n == 2) ? 8'h84 : (n == 3) ? 8'h88 : 8'h1C;
        wr(a, d);
        if (accepted) begin
            w = '0;
            for (int k = 0; k < n; k++) begin
                exp_mosi.push_back(d[8*k +: 8]);
                w[8*(4-n+k) +: 8] = pat(plan_idx + k);
            end
            plan_idx += n;
            exp_rx.push_back(w);
        end
    endtask

    task automatic wait_drain();
        for (int t = 0; t < 20000 && exp_mosi.size() != 0; t++) @(negedge clk);
        repeat (40) @(negedge clk);
    endtask

    task automatic read_rx(input string req);
        logic [31:0] e, got;
        rd(8'h20, got);
        e = (exp_rx.size() != 0) ? exp_rx.pop_front() : 32'hDEAD;
        check(got == e, req, got, e);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state, R9 status encoding
        rd(8'h04, v); check(v == 32'h06, "R1 status at reset", v, 32'h06);
        rd(8'h10, v); check(v == 32'h0, "R1 mask at reset", v, 32'h0);
        check(spi_cs_n == 1'b1 && spi_sclk == 1'b0 && irq == 1'b0, "R1 pins at reset",
              {spi_cs_n, spi_sclk, irq}, 3'b100);

        // R2/R3 all four sizes, mode 0, divide by 2; R6 one select window
        cfg_cpol = 0; cfg_cpha = 0;
        wr(8'h00, 32'h1);
        wr(8'h14, 32'h1);
        cs_rises = 0;
        send(4, 32'h44332211, 1);
        send(1, 32'hAABBCCDD, 1);
        send(2, 32'h0000BEEF, 1);
        send(3, 32'h00C0FFEE, 1);
        wait_drain();
        check(cs_rises == 1, "R6 select held across back-to-back entries", cs_rises, 1);
        for (int i = 0; i < 4; i++) read_rx("R3 packed receive word");
        rd(8'h04, v); check(v == 32'h06, "R9 status after drain", v, 32'h06);

        // R4/R5 mode 3 with code 2
        cfg_cpol = 1; cfg_cpha = 1;
        wr(8'h00, 32'h1 | 32'h2 | 32'h4 | (32'd2 << 3));
        repeat (2) @(negedge clk);
        check(spi_sclk == 1'b1, "R4 idle clock high", spi_sclk, 1);
        send(4, 32'h87654321, 1);
        send(2, 32'h00005AA5, 1);
        wait_drain();
        check(last_period == 8, "R5 clock period for code 2", last_period, 8);
        read_rx("R4 mode3 receive");
        read_rx("R4 mode3 receive");

        // R4 mode 1 with code 1
        cfg_cpol = 0; cfg_cpha = 1;
        wr(8'h00, 32'h1 | 32'h4 | (32'd1 << 3));
        send(3, 32'h00963C71, 1);
        wait_drain();
        check(last_period == 4, "R5 clock period for code 1", last_period, 4);
        read_rx("R4 mode1 receive");

        // R6 manual select
        cfg_cpol = 0; cfg_cpha = 0;
        wr(8'h00, 32'h1 | (32'h1 << 14));
        repeat (2) @(negedge clk);
        check(spi_cs_n == 1'b0, "R6 manual select asserted", spi_cs_n, 0);
        wr(8'h00, 32'h1 | (32'h1 << 14) | (32'h1 << 10));
        repeat (2) @(negedge clk);
        check(spi_cs_n == 1'b1, "R6 manual select released", spi_cs_n, 1);

        // R7 manual start
        wr(8'h00, 32'h1 | (32'h1 << 15));
        send(1, 32'h000000C3, 1);
        repeat (60) @(negedge clk);
        rd(8'h04, v); check(v == 32'h04, "R7 word held until start", v, 32'h04);
        check(spi_cs_n == 1'b1, "R7 no select before start", spi_cs_n, 1);
        wr(8'h00, 32'h1 | (32'h1 << 15) | (32'h1 << 16));
        wait_drain();
        read_rx("R7 receive after start");
        wr(8'h00, 32'h1);

        // R10 underflow, R11 mask and interrupt
        rd(8'h20, v); check(v == 32'h0, "R10 empty read returns zero", v, 0);
        rd(8'h04, v); check(v == 32'h46, "R10 underflow flag", v, 32'h46);
        check(irq == 1'b0, "R11 irq masked", irq, 0);
        wr(8'h08, 32'h40);
        check(irq == 1'b1, "R11 irq on underflow", irq, 1);
        wr(8'h04, 32'h40);
        rd(8'h04, v); check(v == 32'h06, "R10 sticky cleared", v, 32'h06);
        check(irq == 1'b0, "R11 irq cleared", irq, 0);
        wr(8'h08, 32'h02);
        check(irq == 1'b1, "R11 irq on tx empty", irq, 1);
        wr(8'h0C, 32'h02);
        rd(8'h10, v); check(v == 32'h40, "R11 mask after disable", v, 32'h40);
        check(irq == 1'b0, "R11 irq after disable", irq, 0);

        // R8/R9/R10 overflow while gated
        wr(8'h14, 32'h0);
        for (int i = 0; i < 64; i++) send(1, 32'h100 + i, i < 63);
        rd(8'h04, v); check(v == 32'h09, "R10 overflow with full queue", v, 32'h09);
        check(spi_cs_n == 1'b1, "R8 gated engine idle", spi_cs_n, 1);
        wr(8'h04, 32'h01);
        wr(8'h14, 32'h1);
        wait_drain();
        rd(8'h04, v); check(v == 32'h36, "R9 receive queue full", v, 32'h36);
        // R12 stall while receive queue is full
        send(4, 32'hF00DCAFE, 1);
        repeat (100) @(negedge clk);
        check(spi_cs_n == 1'b1, "R12 no start while rx full", spi_cs_n, 1);
        rd(8'h04, v); check(v == 32'h34, "R12 word still queued", v, 32'h34);
        for (int i = 0; i < 63; i++) read_rx("R12 drained receive word");
        wait_drain();
        read_rx("R12 word after room freed");

        // R8 halt mid-entry
        wr(8'h00, 32'h1 | (32'd3 << 3));
        send(4, 32'h13579BDF, 1);
        for (int t = 0; t < 200 && spi_cs_n; t++) @(negedge clk);
        repeat (40) @(negedge clk);
        wr(8'h14, 32'h0);
        repeat (2) @(negedge clk);
        check(spi_cs_n == 1'b1 && spi_sclk == 1'b0, "R8 halt releases pins",
              {spi_cs_n, spi_sclk}, 2'b10);
        repeat (100) @(negedge clk);
        rd(8'h04, v); check(v == 32'h06, "R8 aborted entry yields no result", v, 32'h06);
        exp_mosi.delete();
        finish_run();
    end
endmodule